// File: doc/BRIEF.md
# Audio Converter Start-Up Sequencer

This block supervises how an audio converter and DSP datapath come back to life after a system reset. While the active-low reset input is held low, the block does four things. It parks the ADC data path at all zeros and the DAC code at mid-scale. It keeps frame-clock generation switched off. It holds every internal counter idle.

Once reset is released, the block watches the frame clock (LRCLK) for rising edges. On the first of these it starts an eight-frame sweep that clears the internal working memory. The sweep writes one burst of consecutive addresses per frame, so every address is written exactly once. In parallel, a run counter starts at a point that depends on the clocking mode. In master mode it starts on the first frame after release. In slave mode it starts after two whole frames have elapsed. The block then counts 516 further frames before it declares the ADC data usable and lets it through.

Frame edges are found by comparing LRCLK against a registered copy of itself, so LRCLK must be synchronous to `clk`. The reset input is synchronized in two flops before use. A new reset at any point aborts the sequence. The next release starts everything afresh.

Top module: `audio_reset_seq`

## Requirements
- R1: `sys_rst_n` passes through a two-flop synchronizer. By the third rising `clk` edge after `sys_rst_n` goes low, `cnt_run`, `adc_valid`, `clr_we` and `clr_done` are all 0. This holds from any state, including mid-sequence.
- R2: While reset is in effect, `adc_data_out` is all zeros. After release it stays zero until `adc_valid` is high.
- R3: While reset is in effect, `dac_code_out` equals the mid-scale offset-binary code 2^(DATA_W-1). After release, it follows `dac_code_in` with one clock of delay.
- R4: `lrclk_gen_en` is 0 during reset and becomes 1 within four clocks of `sys_rst_n` going high.
- R5: A rising edge is a cycle where `lrclk` is sampled high after being sampled low. Edges that occur during reset are not counted, so counting begins with the first edge after release.
- R6: Memory clear starts at the first LRCLK rise after release.
  - At rise k (k = 1..8), `clr_we` pulses for DEPTH/8 consecutive clocks.
  - The addresses in each burst run upward from (k-1)·DEPTH/8.
  - Over the eight bursts, every address 0..DEPTH-1 is written once, in ascending order.
- R7: `clr_done` rises on the 9th LRCLK rise after release. No clear writes occur after that.
- R8: In master mode (`master_mode`=1), `cnt_run` goes high on the first LRCLK rise after release. It stays high until reset.
- R9: In slave mode (`master_mode`=0), `cnt_run` stays low for the first two rises and goes high on the third.
- R10: `adc_valid` rises on the 516th LRCLK rise after the rise that set `cnt_run`. From the next clock on, `adc_data_out` equals `adc_data_in` delayed by one clock.
- R11: If reset arrives in the middle of the clear sweep, the next release restarts the sweep from address 0. The frame counts also start again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low system reset, synchronized inside |
| master_mode | input | 1 | 1 = master clocking, 0 = slave clocking; change only in reset |
| lrclk | input | 1 | Frame clock, synchronous to `clk` |
| adc_data_in | input | DATA_W | Raw ADC sample word |
| dac_code_in | input | DATA_W | DAC code from the datapath (offset binary) |
| lrclk_gen_en | output | 1 | Enable for master-mode frame/bit clock generation |
| clr_we | output | 1 | Memory-clear write enable |
| clr_addr | output | $clog2(DEPTH) | Memory-clear write address |
| clr_done | output | 1 | Memory clear finished |
| cnt_run | output | 1 | Internal frame counter running |
| adc_valid | output | 1 | ADC data may be used |
| adc_data_out | output | DATA_W | Gated ADC word |
| dac_code_out | output | DATA_W | Gated DAC code |

## Verification
The bench toggles LRCLK during reset. A design that counted those edges would start clearing and running one or more frames early.

It runs master and slave releases back to back and checks the start frame and the 516-frame valid point on each side. An off-by-one in either counter, or a swapped mode meaning, moves `cnt_run` or `adc_valid` by a whole frame.

A scoreboard compares every clear write address against the expected ascending sweep. This catches a wrong burst base, a skipped or repeated address, or a burst of the wrong length.

A reset in the middle of the sweep, followed by a second release, shows whether stale frame or address state survives reset.

// File: rtl/ars_pkg.sv
package ars_pkg;
  typedef enum logic {
    MODE_SLAVE  = 1'b0,
    MODE_MASTER = 1'b1
  } clk_mode_e;
endpackage

// File: rtl/ars_rst_sync.sv
module ars_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_out
);
  logic [STAGES-1:0] sync_q = '0;

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[STAGES-2:0], rst_n_in};
  end

  // active-high synchronous reset for the rest of the block
  assign rst_out = ~sync_q[STAGES-1];
endmodule

// File: rtl/ars_edge_det.sv
module ars_edge_det (
  input  logic clk,
  input  logic sig,
  output logic rise
);
  logic sig_q = 1'b0;

  always_ff @(posedge clk) begin
    sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/ars_mem_clear.sv
module ars_mem_clear #(
  parameter int DEPTH  = 64,
  parameter int FRAMES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rise,
  output logic                     we,
  output logic [$clog2(DEPTH)-1:0] addr,
  output logic                     done
);
  localparam int STEP   = DEPTH / FRAMES;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int OFF_W  = (STEP > 1) ? $clog2(STEP) : 1;
  localparam int FI_W   = $clog2(FRAMES + 1);

  logic [FI_W-1:0] frame_idx;
  logic            burst_last;

  assign burst_last = (addr[OFF_W-1:0] == OFF_W'(STEP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      we        <= 1'b0;
      addr      <= '0;
      frame_idx <= '0;
      done      <= 1'b0;
    end else if (rise && !done) begin
      if (frame_idx == FI_W'(FRAMES)) begin
        done <= 1'b1;
        we   <= 1'b0;
      end else begin
        we        <= 1'b1;
        addr      <= ADDR_W'(int'(frame_idx) * STEP);
        frame_idx <= frame_idx + 1'b1;
      end
    end else if (we) begin
      if (burst_last) we <= 1'b0;
      else            addr <= addr + 1'b1;
    end
  end

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !we);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    (we && $past(we) && !$past(rise)) |-> (addr == $past(addr) + 1'b1));

  p_burst_base_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(we) |-> (addr[OFF_W-1:0] == '0));
endmodule

// File: rtl/ars_frame_timer.sv
module ars_frame_timer
  import ars_pkg::*;
#(
  parameter int VALID_FRAMES = 516,
  parameter int SLAVE_DELAY  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic master_mode,
  output logic run,
  output logic valid
);
  localparam int PRE_W = $clog2(SLAVE_DELAY + 2);
  localparam int V_W   = $clog2(VALID_FRAMES + 1);

  clk_mode_e   mode;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] start_at;
  logic [V_W-1:0]   val_cnt;

  assign mode     = clk_mode_e'(master_mode);
  assign start_at = (mode == MODE_MASTER) ? PRE_W'(1) : PRE_W'(SLAVE_DELAY + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      run     <= 1'b0;
      val_cnt <= '0;
      valid   <= 1'b0;
    end else if (rise) begin
      if (!run) begin
        if (pre_cnt + 1'b1 == start_at) run <= 1'b1;
        else                            pre_cnt <= pre_cnt + 1'b1;
      end else if (!valid) begin
        if (val_cnt == V_W'(VALID_FRAMES - 1)) valid <= 1'b1;
        else                                   val_cnt <= val_cnt + 1'b1;
      end
    end
  end

  p_valid_needs_run_r10: assert property (@(posedge clk) disable iff (rst)
    valid |-> run);

  p_run_holds_r8: assert property (@(posedge clk) disable iff (rst)
    run |=> run);

  p_run_on_edge_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(rise));

  p_valid_on_edge_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(rise));
endmodule

// File: rtl/audio_reset_seq.sv
module audio_reset_seq #(
  parameter int DATA_W       = 24,
  parameter int DEPTH        = 64,
  parameter int CLR_FRAMES   = 8,
  parameter int VALID_FRAMES = 516,
  parameter int SLAVE_DELAY  = 2
) (
  input  logic                     clk,
  input  logic                     sys_rst_n,
  input  logic                     master_mode,
  input  logic                     lrclk,
  input  logic [DATA_W-1:0]        adc_data_in,
  input  logic [DATA_W-1:0]        dac_code_in,
  output logic                     lrclk_gen_en,
  output logic                     clr_we,
  output logic [$clog2(DEPTH)-1:0] clr_addr,
  output logic                     clr_done,
  output logic                     cnt_run,
  output logic                     adc_valid,
  output logic [DATA_W-1:0]        adc_data_out,
  output logic [DATA_W-1:0]        dac_code_out
);
  localparam logic [DATA_W-1:0] DAC_MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic rst;
  logic lr_rise;

  ars_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n_in(sys_rst_n), .rst_out(rst)
  );

  ars_edge_det u_edge (
    .clk(clk), .sig(lrclk), .rise(lr_rise)
  );

  ars_mem_clear #(.DEPTH(DEPTH), .FRAMES(CLR_FRAMES)) u_clear (
    .clk(clk), .rst(rst), .rise(lr_rise),
    .we(clr_we), .addr(clr_addr), .done(clr_done)
  );

  ars_frame_timer #(.VALID_FRAMES(VALID_FRAMES), .SLAVE_DELAY(SLAVE_DELAY)) u_timer (
    .clk(clk), .rst(rst), .rise(lr_rise), .master_mode(master_mode),
    .run(cnt_run), .valid(adc_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lrclk_gen_en <= 1'b0;
      adc_data_out <= '0;
      dac_code_out <= DAC_MID;
    end else begin
      lrclk_gen_en <= 1'b1;
      adc_data_out <= adc_valid ? adc_data_in : '0;
      dac_code_out <= dac_code_in;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!cnt_run && !adc_valid && !clr_we && !clr_done));

  p_adc_zero_r2: assert property (@(posedge clk)
    rst |=> (adc_data_out == '0));

  p_adc_gated_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(adc_valid) |-> (adc_data_out == '0));

  p_dac_mid_r3: assert property (@(posedge clk)
    rst |=> (dac_code_out == DAC_MID));

  p_gen_off_r4: assert property (@(posedge clk)
    rst |=> !lrclk_gen_en);
endmodule

// File: tb/tb_audio_reset_seq.sv
module tb_audio_reset_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW     = 24;
  localparam int DEPTH  = 64;
  localparam int CLRF   = 8;
  localparam int VALIDF = 516;
  localparam int SDELAY = 2;
  localparam int HALF   = 8;
  localparam int AW     = $clog2(DEPTH);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic          clk = 1'b0;
  logic          sys_rst_n = 1'b0;
  logic          master_mode = 1'b1;
  logic          lrclk = 1'b0;
  logic [DW-1:0] adc_data_in = 24'h5A3C71;
  logic [DW-1:0] dac_code_in = 24'h123456;
  logic          lrclk_gen_en, clr_we, clr_done, cnt_run, adc_valid;
  logic [AW-1:0] clr_addr;
  logic [DW-1:0] adc_data_out, dac_code_out;

  int tests = 0;
  int fails = 0;
  int frame_no = 0;
  int start_idx = 1;
  string mon_req = "R6";
  int unsigned exp_q[$];

  audio_reset_seq #(.DATA_W(DW), .DEPTH(DEPTH), .CLR_FRAMES(CLRF),
                    .VALID_FRAMES(VALIDF), .SLAVE_DELAY(SDELAY)) dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .master_mode(master_mode), .lrclk(lrclk),
    .adc_data_in(adc_data_in), .dac_code_in(dac_code_in),
    .lrclk_gen_en(lrclk_gen_en), .clr_we(clr_we), .clr_addr(clr_addr),
    .clr_done(clr_done), .cnt_run(cnt_run), .adc_valid(adc_valid),
    .adc_data_out(adc_data_out), .dac_code_out(dac_code_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h (frame %0d)", req, what, act, exp, frame_no);
    end
  endtask

  // scoreboard monitor: every clear write must match the next expected address
  always @(negedge clk) begin
    if (clr_we) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected clear write: actual=%0d expected=none", mon_req, clr_addr);
      end else begin
        int unsigned e;
        e = exp_q.pop_front();
        if (int'(clr_addr) != int'(e)) begin
          fails++;
          $display("FAIL %s clear address: actual=%0d expected=%0d", mon_req, clr_addr, e);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check_rise();
    string rq;
    rq = master_mode ? "R8" : "R9";
    check(rq, "cnt_run", cnt_run, frame_no >= start_idx);
    check("R10", "adc_valid", adc_valid, frame_no >= start_idx + VALIDF);
    check("R7", "clr_done", clr_done, frame_no >= CLRF + 1);
    if (frame_no == 1) check("R6", "first write addr", clr_addr, 0);
  endtask

  task automatic check_late();
    if (frame_no >= start_idx + VALIDF)
      check("R10", "adc_data_out", adc_data_out, adc_data_in);
    else
      check("R2", "adc_data_out gated", adc_data_out, 0);
    if (frame_no == CLRF + 1) check("R6", "pending clear writes", exp_q.size(), 0);
  endtask

  task automatic run_frame();
    lrclk = 1'b1;
    frame_no++;
    @(negedge clk);
    check_rise();
    @(negedge clk);
    check_late();
    repeat (HALF-2) @(negedge clk);
    lrclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic reset_frame();
    lrclk = 1'b1;
    repeat (HALF) @(negedge clk);
    check("R5", "cnt_run in reset", cnt_run, 0);
    check("R2", "adc zero in reset", adc_data_out, 0);
    check("R3", "dac mid in reset", dac_code_out, MID);
    check("R4", "gen off in reset", lrclk_gen_en, 0);
    check("R5", "no clear in reset", clr_we, 0);
    lrclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic do_reset();
    sys_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "cnt_run", cnt_run, 0);
    check("R1", "adc_valid", adc_valid, 0);
    check("R1", "clr_we", clr_we, 0);
    check("R1", "clr_done", clr_done, 0);
    exp_q.delete();
  endtask

  task automatic do_release(logic m, string req);
    master_mode = m;
    mon_req = req;
    for (int a = 0; a < DEPTH; a++) exp_q.push_back(a);
    frame_no = 0;
    start_idx = m ? 1 : SDELAY + 1;
    sys_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R4", "gen enabled", lrclk_gen_en, 1);
    check("R3", "dac follows input", dac_code_out, dac_code_in);
    check("R5", "idle before first rise", cnt_run, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    repeat (3) reset_frame();

    // master-mode release, full sequence
    do_release(1'b1, "R6");
    repeat (VALIDF + 3) run_frame();

    // reset out of the running state
    do_reset();
    dac_code_in = 24'hFEDCBA;
    repeat (2) reset_frame();

    // slave release aborted in the middle of the clear sweep
    do_release(1'b0, "R6");
    repeat (4) run_frame();
    do_reset();
    reset_frame();

    // slave release again: sweep must restart from address 0
    adc_data_in = 24'hC0FFEE;
    do_release(1'b0, "R11");
    repeat (VALIDF + SDELAY + 3) run_frame();
    check("R11", "all clear writes seen", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule